// File: doc/BRIEF.md
# Pipeline Operand Forwarding Select

This block decides where each operand of a five-stage in-order pipeline comes from when an older instruction has not yet written its result back. For the two ALU operands of the instruction in the execute stage it compares the source register numbers with the destination registers of the two older instructions, one in the memory stage and one in write-back. It then produces a 2-bit select for each operand's bypass multiplexer. The multiplexer can take the memory-stage result, the write-back result or the value read from the register file.

A second pair of 1-bit selects serves the equality comparator in the decode stage, which resolves branches early. When decode holds a branch whose source register is being produced by the instruction now in the memory stage, the comparator takes that result instead of the register-file value. The write-back result never needs a decode bypass, because the register file writes early in the cycle and reads late. All outputs are purely combinational. The bypass multiplexers, the register file and stall generation are outside this block.

Top module: `fwd_select`

## Requirements
- R1: The execute-stage select codes are 2'b00 for the register-file value, 2'b01 for the write-back result and 2'b10 for the memory-stage result. Code 2'b11 is never produced. Operand A uses `ex_src_a` and operand B uses `ex_src_b`.
- R2: An operand's execute select is 2'b10 whenever `mem_wr` is 1, `mem_dst` is nonzero and `mem_dst` equals that operand's source register.
- R3: An operand's execute select is 2'b01 when `wb_wr` is 1, `wb_dst` is nonzero, `wb_dst` equals that operand's source register, and the memory-stage condition of R2 does not hold for that operand.
- R4: When both older stages write the same nonzero register that an operand reads, the memory-stage result wins (select 2'b10).
- R5: Register number 0 is never forwarded. A source of 0 gives execute select 2'b00 and decode select 0, whatever the destinations and write enables are.
- R6: A stage whose write enable is 0 never causes a forward, even when its destination matches a source.
- R7: A decode select (`dec_sel_a` for `dec_src_a`, `dec_sel_b` for `dec_src_b`) is 1 when `dec_branch` is 1, `mem_wr` is 1, `mem_dst` is nonzero and `mem_dst` equals that source. Otherwise it is 0.
- R8: With `dec_branch` at 0, both decode selects are 0.
- R9: A match against the write-back destination alone never sets a decode select.
- R10: The two operands are decided independently. Each select depends only on its own source register and the shared destination fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a | input | REG_W | First source register of the execute-stage instruction |
| ex_src_b | input | REG_W | Second source register of the execute-stage instruction |
| mem_dst | input | REG_W | Destination register of the memory-stage instruction |
| mem_wr | input | 1 | Memory-stage instruction writes a register |
| wb_dst | input | REG_W | Destination register of the write-back instruction |
| wb_wr | input | 1 | Write-back instruction writes a register |
| dec_branch | input | 1 | Decode stage holds a branch |
| dec_src_a | input | REG_W | First source register of the decode-stage instruction |
| dec_src_b | input | REG_W | Second source register of the decode-stage instruction |
| ex_sel_a | output | 2 | Bypass select for execute operand A |
| ex_sel_b | output | 2 | Bypass select for execute operand B |
| dec_sel_a | output | 1 | Bypass select for decode comparator input A |
| dec_sel_b | output | 1 | Bypass select for decode comparator input B |

## Verification
The bench targets a series of writes to the same register. If the design ordered the stages wrongly, it would hand the older write-back value to the ALU when the memory stage also matches. It drives register 0 as a destination with the write enable high, because a design that forgot the zero check would bypass a garbage result in place of the hard-wired zero. It also checks that a matching destination with its write enable low stays unforwarded. Other cases exercise a write-back-only match while a branch sits in decode and a branch-free decode with a memory match. A design that bypassed there would misroute the comparator. Random register numbers drawn from a small range then cause frequent partial matches, so that an operand crossed with the other one shows up.

// File: rtl/fwd_select.sv
module fwd_select #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] ex_src_a,
  input  logic [REG_W-1:0] ex_src_b,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             mem_wr,
  input  logic [REG_W-1:0] wb_dst,
  input  logic             wb_wr,
  input  logic             dec_branch,
  input  logic [REG_W-1:0] dec_src_a,
  input  logic [REG_W-1:0] dec_src_b,
  output logic [1:0]       ex_sel_a,
  output logic [1:0]       ex_sel_b,
  output logic             dec_sel_a,
  output logic             dec_sel_b
);

  localparam logic [1:0] SEL_RF  = 2'b00;
  localparam logic [1:0] SEL_WB  = 2'b01;
  localparam logic [1:0] SEL_MEM = 2'b10;
  localparam int         NOPS    = 2;

  logic             mem_live, wb_live;
  logic [REG_W-1:0] ex_src  [NOPS];
  logic [REG_W-1:0] dec_src [NOPS];
  logic [1:0]       ex_sel  [NOPS];
  logic             dec_sel [NOPS];

  assign mem_live = mem_wr && (mem_dst != '0);
  assign wb_live  = wb_wr  && (wb_dst  != '0);

  assign ex_src[0]  = ex_src_a;
  assign ex_src[1]  = ex_src_b;
  assign dec_src[0] = dec_src_a;
  assign dec_src[1] = dec_src_b;

  for (genvar i = 0; i < NOPS; i++) begin : g_op
    logic hit_mem, hit_wb;
    assign hit_mem    = mem_live && (mem_dst == ex_src[i]);
    assign hit_wb     = wb_live  && (wb_dst  == ex_src[i]);
    assign ex_sel[i]  = hit_mem ? SEL_MEM : (hit_wb ? SEL_WB : SEL_RF);
    assign dec_sel[i] = dec_branch && mem_live && (mem_dst == dec_src[i]);

    always_comb begin
      p_code_legal_r1: assert (ex_sel[i] != 2'b11);
      if (ex_src[i] == '0) begin
        p_zero_ex_r5: assert (ex_sel[i] == SEL_RF);
      end
      if (dec_src[i] == '0) begin
        p_zero_dec_r5: assert (!dec_sel[i]);
      end
      if (!mem_wr && !wb_wr) begin
        p_no_writer_r6: assert (ex_sel[i] == SEL_RF && !dec_sel[i]);
      end
      if (mem_wr && wb_wr && mem_dst == wb_dst && mem_dst == ex_src[i] && ex_src[i] != '0) begin
        p_mem_wins_r4: assert (ex_sel[i] == SEL_MEM);
      end
      if (!dec_branch) begin
        p_dec_idle_r8: assert (!dec_sel[i]);
      end
      if (dec_sel[i]) begin
        p_dec_needs_mem_r7: assert (mem_wr && mem_dst == dec_src[i]);
      end
    end
  end

  assign ex_sel_a  = ex_sel[0];
  assign ex_sel_b  = ex_sel[1];
  assign dec_sel_a = dec_sel[0];
  assign dec_sel_b = dec_sel[1];

endmodule

// File: tb/fwd_select_bench.sv
module fwd_select_bench;
  localparam int REG_W = 5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [REG_W-1:0] ex_src_a, ex_src_b, mem_dst, wb_dst, dec_src_a, dec_src_b;
  logic             mem_wr, wb_wr, dec_branch;
  logic [1:0]       ex_sel_a, ex_sel_b;
  logic             dec_sel_a, dec_sel_b;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  fwd_select #(.REG_W(REG_W)) u_fwd_select (
    .ex_src_a(ex_src_a), .ex_src_b(ex_src_b),
    .mem_dst(mem_dst), .mem_wr(mem_wr),
    .wb_dst(wb_dst), .wb_wr(wb_wr),
    .dec_branch(dec_branch),
    .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
    .ex_sel_a(ex_sel_a), .ex_sel_b(ex_sel_b),
    .dec_sel_a(dec_sel_a), .dec_sel_b(dec_sel_b)
  );

  function automatic logic [1:0] exp_ex(input logic [REG_W-1:0] s);
    if (mem_wr && mem_dst != 0 && mem_dst == s) return 2'b10;
    if (wb_wr && wb_dst != 0 && wb_dst == s) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic exp_dec(input logic [REG_W-1:0] s);
    return dec_branch && mem_wr && mem_dst != 0 && mem_dst == s;
  endfunction

  task automatic check_all(input string tag);
    logic [1:0] ea, eb;
    logic da, db;
    @(negedge clk);
    #1;
    ea = exp_ex(ex_src_a); eb = exp_ex(ex_src_b);
    da = exp_dec(dec_src_a); db = exp_dec(dec_src_b);
    checks++;
    if (ex_sel_a !== ea || ex_sel_b !== eb || dec_sel_a !== da || dec_sel_b !== db) begin
      errors++;
      $display("FAIL %s ex_a %b/%b ex_b %b/%b dec_a %b/%b dec_b %b/%b (actual/expected)",
               tag, ex_sel_a, ea, ex_sel_b, eb, dec_sel_a, da, dec_sel_b, db);
    end
  endtask

  task automatic drive(input logic [REG_W-1:0] sa, input logic [REG_W-1:0] sb,
                       input logic [REG_W-1:0] md, input logic mw,
                       input logic [REG_W-1:0] wd, input logic ww,
                       input logic br, input logic [REG_W-1:0] da,
                       input logic [REG_W-1:0] db);
    @(posedge clk);
    ex_src_a = sa; ex_src_b = sb; mem_dst = md; mem_wr = mw;
    wb_dst = wd; wb_wr = ww; dec_branch = br; dec_src_a = da; dec_src_b = db;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    ex_src_a = 0; ex_src_b = 0; mem_dst = 0; mem_wr = 0;
    wb_dst = 0; wb_wr = 0; dec_branch = 0; dec_src_a = 0; dec_src_b = 0;
    check_all("R1 idle");
    if (ex_sel_a !== 2'b00 || dec_sel_a !== 1'b0) begin
      errors++; $display("FAIL R1 idle select not zero %b", ex_sel_a);
    end
    drive(3, 4, 3, 1, 9, 0, 0, 0, 0);   check_all("R2 mem to A");
    drive(3, 4, 4, 1, 9, 0, 0, 0, 0);   check_all("R2 mem to B");
    drive(7, 8, 1, 0, 7, 1, 0, 0, 0);   check_all("R3 wb to A");
    drive(7, 8, 9, 1, 8, 1, 0, 0, 0);   check_all("R3 wb to B");
    drive(6, 6, 6, 1, 6, 1, 0, 0, 0);   check_all("R4 mem wins both");
    drive(6, 2, 6, 1, 2, 1, 0, 0, 0);   check_all("R4 R10 split sources");
    drive(0, 0, 0, 1, 0, 1, 1, 0, 0);   check_all("R5 zero register");
    drive(5, 0, 5, 0, 5, 0, 1, 5, 5);   check_all("R6 write disabled");
    drive(5, 5, 5, 0, 5, 1, 0, 0, 0);   check_all("R6 mem disabled wb live");
    drive(1, 1, 12, 1, 0, 0, 1, 12, 13); check_all("R7 branch A");
    drive(1, 1, 13, 1, 0, 0, 1, 12, 13); check_all("R7 branch B");
    drive(1, 1, 12, 1, 0, 0, 0, 12, 12); check_all("R8 no branch");
    drive(1, 1, 3, 1, 12, 1, 1, 12, 12); check_all("R9 wb only in decode");
    drive(0, 0, 0, 1, 0, 0, 1, 0, 0);   check_all("R5 zero in decode");
    void'($urandom(32'd4242));
    for (int n = 0; n < 2000; n++) begin
      drive($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
            1'($urandom), $urandom_range(0, 3), 1'($urandom), 1'($urandom),
            $urandom_range(0, 3), $urandom_range(0, 3));
      check_all("R10 random");
    end
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule